// File: doc/BRIEF.md
# Keyboard controller host command processor

This block is the command side of a PC-style keyboard controller built in logic. The host writes bytes through one input stream, each tagged as either a command byte or a data byte. The block decodes the commands and keeps a 64-byte internal RAM. Location 20h of that RAM is the controller's command byte, and location 2Bh is the base used for relative addressing. Any reply goes into a one-byte output buffer that the host drains. A data byte that no command is waiting for is passed toward the keyboard link.

After power-on the controller stays inactive until it receives the self-test command. Self-test also returns the controller to a known state. The controller drives these outputs:
- the CPU reset line and the A20 gate, both taken from its output port;
- a keyboard-interface-off flag;
- a translation-enable flag;
- an interrupt request.

The diagnostic dump and input-port poll requests are not carried out here. The block only raises a one-cycle request pulse for each.

Back-pressure works as follows. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the output buffer holds an unread reply, and also while a forwarded keyboard byte has not been taken. `out_valid` and `kbd_valid` stay high, with their data unchanged, until the matching ready input is seen high at a clock edge. The host must therefore drain every reply before it writes again.

Top module: `kbc_host_cmd`

## Requirements
- R1: From reset until the first accepted command byte AAh, `ctrl_active` is 0. During that time every other accepted byte is ignored: it produces no reply, no keyboard byte and no RAM change.
- R2: An accepted command AAh loads reply 55h and sets `ctrl_active`. It sets the command byte to 50h (bit 4 = interface off, bit 6 = translation on, bit 0 = interrupt enable off). It sets the output port to 03h (bit 1 = A20 enabled, bit 0 = CPU reset released) and RAM[2Bh] to 20h.
- R3: Command 20h–3Fh replies with RAM[20h + cmd[4:0]]. Command 60h–7Fh writes the next data byte to that same address.
- R4: Command 00h–1Fh (read) and command 40h–5Fh (write) use the address (RAM[2Bh] + cmd[4:0]) mod 64.
- R5: Any RAM write whose address is 20h stores bits 7 and 3 as 0, whether the address was direct or relative.
- R6: Command ADh sets command-byte bit 4, so `kbd_if_off` = 1. Command AEh clears it.
- R7: When no parameter is pending, a data byte is presented on `kbd_data` with `kbd_valid`, held until `kbd_ready`, and it clears command-byte bit 4.
- R8: Command D1h writes the next data byte to the output port: `cpu_reset_n` = bit 0, `a20_en` = bit 1. Command D0h replies with the output port.
- R9: Commands 80h–A8h, AFh–BFh, C3h–CFh, D2h–DEh and E1h–EFh give no reply and change no state.
- R10: A command byte that arrives while a parameter is pending cancels the wait. A data byte after it is treated as a keyboard byte.
- R11: `out_valid` and `out_data` hold until `out_ready`. `in_ready` is 0 while `out_valid` or `kbd_valid` is 1.
- R12: `kbd_irq` is 1 exactly while `out_valid` is 1 and command-byte bit 0 is 1.
- R13: Command ACh gives a one-cycle `dump_req` pulse. Commands C1h and C2h give a one-cycle `poll_req` pulse. None of the three gives a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block can accept a host byte |
| in_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Output buffer full |
| out_ready | input | 1 | Host reads the output buffer |
| out_data | output | 8 | Reply byte |
| kbd_valid | output | 1 | Byte for the keyboard link valid |
| kbd_ready | input | 1 | Keyboard link takes the byte |
| kbd_data | output | 8 | Byte for the keyboard link |
| kbd_irq | output | 1 | Keyboard interrupt request |
| kbd_if_off | output | 1 | Keyboard interface disabled |
| xlate_en | output | 1 | Scan-code translation enabled |
| a20_en | output | 1 | A20 gate enable |
| cpu_reset_n | output | 1 | CPU reset, active low |
| ctrl_active | output | 1 | Self-test has been completed |
| dump_req | output | 1 | Diagnostic dump request pulse |
| poll_req | output | 1 | Input-port poll request pulse |

## Verification
The assertions check several behaviours on every cycle:
- the state that follows a self-test;
- that no keyboard byte appears while the controller is inactive;
- the implicit interface enable after a keyboard data byte;
- the hold of both output streams under back-pressure;
- the reserved command-byte bits staying zero;
- the silence of the no-op commands.

Only the bench scenarios can show that addressing resolves to the right location: the relative-address alias, the modulo-64 wrap, and a cancelled parameter wait that leaves RAM untouched. The same holds for the output-port values and the pulse requests.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_SELFTEST = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_KBD_OFF  = 8'hAD;
  localparam logic [BYTE_W-1:0] CMD_KBD_ON   = 8'hAE;
  localparam logic [BYTE_W-1:0] CMD_RD_OUTP  = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_WR_OUTP  = 8'hD1;
  localparam logic [BYTE_W-1:0] CMD_DUMP     = 8'hAC;
  localparam logic [BYTE_W-1:0] CMD_POLL_HI  = 8'hC1;
  localparam logic [BYTE_W-1:0] CMD_POLL_LO  = 8'hC2;

  localparam int IF_OFF_BIT = 4;
  localparam int XLATE_BIT  = 6;
  localparam int IRQ_EN_BIT = 0;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD, OP_WR, OP_SELFTEST, OP_KBD_OFF, OP_KBD_ON,
    OP_RD_OUTP, OP_WR_OUTP, OP_DUMP, OP_POLL
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       rel;
    logic [4:0] ofs;
  } dec_t;

  typedef enum logic [1:0] {S_OFF, S_IDLE, S_WR_RAM, S_WR_OUTP} st_e;
endpackage

// File: rtl/kbc_decode.sv
module kbc_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output dec_t              dec
);
  always_comb begin
    dec.ofs = cmd[4:0];
    dec.rel = !cmd[5];
    unique case (cmd[7:6])
      2'b00: dec.op = OP_RD;
      2'b01: dec.op = OP_WR;
      default: begin
        unique case (cmd)
          CMD_SELFTEST: dec.op = OP_SELFTEST;
          CMD_KBD_OFF:  dec.op = OP_KBD_OFF;
          CMD_KBD_ON:   dec.op = OP_KBD_ON;
          CMD_RD_OUTP:  dec.op = OP_RD_OUTP;
          CMD_WR_OUTP:  dec.op = OP_WR_OUTP;
          CMD_DUMP:     dec.op = OP_DUMP;
          CMD_POLL_HI,
          CMD_POLL_LO:  dec.op = OP_POLL;
          default:      dec.op = OP_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/kbc_ram.sv
module kbc_ram
  import kbc_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h2B,
  parameter logic [BYTE_W-1:0] CMD_INIT  = 8'h50,
  parameter logic [BYTE_W-1:0] BASE_INIT = 8'h20,
  parameter logic [BYTE_W-1:0] RSV_MASK  = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] base,
  output logic [BYTE_W-1:0] cmd_byte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam bit IS_CMD  = (i == int'(CMD_ADDR));
    localparam bit IS_BASE = (i == int'(BASE_ADDR));
    localparam logic [BYTE_W-1:0] RST_V =
      IS_CMD ? CMD_INIT : (IS_BASE ? BASE_INIT : '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[i] <= RST_V;
      else if (init && (IS_CMD || IS_BASE))    mem[i] <= RST_V;
      else if (we && waddr == ADDR_W'(i))      mem[i] <= wdata;
    end
  end

  assign rdata    = mem[raddr];
  assign base     = mem[BASE_ADDR];
  assign cmd_byte = mem[CMD_ADDR];

  // R5: the reserved command-byte bits never become set
  p_rsv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte & RSV_MASK) == '0);
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: a reply waits with stable data until it is read
  p_hold_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/kbc_host_cmd.sv
module kbc_host_cmd
  import kbc_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [BYTE_W-1:0] CMD_INIT    = 8'h50,
  parameter logic [BYTE_W-1:0] BASE_INIT   = 8'h20,
  parameter logic [BYTE_W-1:0] OUTP_INIT   = 8'h03,
  parameter logic [BYTE_W-1:0] RSV_MASK    = 8'h88,
  parameter logic [BYTE_W-1:0] SELFTEST_OK = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_cmd,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              kbd_valid,
  input  logic              kbd_ready,
  output logic [BYTE_W-1:0] kbd_data,
  output logic              kbd_irq,
  output logic              kbd_if_off,
  output logic              xlate_en,
  output logic              a20_en,
  output logic              cpu_reset_n,
  output logic              ctrl_active,
  output logic              dump_req,
  output logic              poll_req
);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(1 << (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] BASE_ADDR = CMD_ADDR + ADDR_W'(11);
  localparam logic [BYTE_W-1:0] IF_OFF_M  = BYTE_W'(1 << IF_OFF_BIT);

  st_e               state, state_nxt;
  dec_t              dec;
  logic              accept;
  logic [ADDR_W-1:0] addr_dir, addr_rel, addr_now, wr_addr;
  logic [BYTE_W-1:0] base, cmd_byte, ram_rdata, outport, outport_nxt;
  logic [BYTE_W-1:0] rel_sum;
  logic              unused_sum;
  logic              ram_init, ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [BYTE_W-1:0] ram_wraw, ram_wdata;
  logic              ob_load;
  logic [BYTE_W-1:0] ob_data;
  logic              kbd_load, dump_nxt, poll_nxt, cap_addr;

  kbc_decode u_dec (.cmd(in_data), .dec(dec));

  assign accept   = in_valid && in_ready;
  assign addr_dir = CMD_ADDR + ADDR_W'(dec.ofs);
  assign rel_sum  = base + BYTE_W'(dec.ofs);
  assign addr_rel = rel_sum[ADDR_W-1:0];
  assign unused_sum = ^rel_sum;
  assign addr_now = dec.rel ? addr_rel : addr_dir;
  assign ram_wdata = (ram_waddr == CMD_ADDR) ? (ram_wraw & ~RSV_MASK) : ram_wraw;

  kbc_ram #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .BASE_ADDR(BASE_ADDR),
    .CMD_INIT(CMD_INIT), .BASE_INIT(BASE_INIT), .RSV_MASK(RSV_MASK)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .init(ram_init), .we(ram_we),
    .waddr(ram_waddr), .wdata(ram_wdata), .raddr(addr_now),
    .rdata(ram_rdata), .base(base), .cmd_byte(cmd_byte)
  );

  kbc_outbuf u_ob (
    .clk(clk), .rst_n(rst_n), .load(ob_load), .load_data(ob_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always_comb begin
    state_nxt   = state;
    outport_nxt = outport;
    ram_init    = 1'b0;
    ram_we      = 1'b0;
    ram_waddr   = CMD_ADDR;
    ram_wraw    = cmd_byte;
    ob_load     = 1'b0;
    ob_data     = ram_rdata;
    kbd_load    = 1'b0;
    dump_nxt    = 1'b0;
    poll_nxt    = 1'b0;
    cap_addr    = 1'b0;
    if (accept) begin
      if (state == S_OFF) begin
        if (in_is_cmd && in_data == CMD_SELFTEST) begin
          state_nxt   = S_IDLE;
          ram_init    = 1'b1;
          outport_nxt = OUTP_INIT;
          ob_load     = 1'b1;
          ob_data     = SELFTEST_OK;
        end
      end else if (in_is_cmd) begin
        state_nxt = S_IDLE;
        unique case (dec.op)
          OP_RD:       ob_load = 1'b1;
          OP_WR: begin
            state_nxt = S_WR_RAM;
            cap_addr  = 1'b1;
          end
          OP_SELFTEST: begin
            ram_init    = 1'b1;
            outport_nxt = OUTP_INIT;
            ob_load     = 1'b1;
            ob_data     = SELFTEST_OK;
          end
          OP_KBD_OFF: begin
            ram_we   = 1'b1;
            ram_wraw = cmd_byte | IF_OFF_M;
          end
          OP_KBD_ON: begin
            ram_we   = 1'b1;
            ram_wraw = cmd_byte & ~IF_OFF_M;
          end
          OP_RD_OUTP: begin
            ob_load = 1'b1;
            ob_data = outport;
          end
          OP_WR_OUTP: state_nxt = S_WR_OUTP;
          OP_DUMP:    dump_nxt  = 1'b1;
          OP_POLL:    poll_nxt  = 1'b1;
          default: ;
        endcase
      end else begin
        state_nxt = S_IDLE;
        unique case (state)
          S_WR_RAM: begin
            ram_we    = 1'b1;
            ram_waddr = wr_addr;
            ram_wraw  = in_data;
          end
          S_WR_OUTP: outport_nxt = in_data;
          default: begin
            kbd_load = 1'b1;
            ram_we   = 1'b1;
            ram_wraw = cmd_byte & ~IF_OFF_M;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      outport   <= OUTP_INIT;
      wr_addr   <= '0;
      kbd_valid <= 1'b0;
      kbd_data  <= '0;
      dump_req  <= 1'b0;
      poll_req  <= 1'b0;
    end else begin
      state    <= state_nxt;
      outport  <= outport_nxt;
      dump_req <= dump_nxt;
      poll_req <= poll_nxt;
      if (cap_addr) wr_addr <= addr_now;
      if (kbd_load) begin
        kbd_valid <= 1'b1;
        kbd_data  <= in_data;
      end else if (kbd_ready) begin
        kbd_valid <= 1'b0;
      end
    end
  end

  assign in_ready    = !out_valid && !kbd_valid;
  assign ctrl_active = (state != S_OFF);
  assign kbd_if_off  = cmd_byte[IF_OFF_BIT];
  assign xlate_en    = cmd_byte[XLATE_BIT];
  assign kbd_irq     = out_valid && cmd_byte[IRQ_EN_BIT];
  assign a20_en      = outport[1];
  assign cpu_reset_n = outport[0];

  // R1: nothing reaches the keyboard while the controller is inactive
  p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_active |=> !kbd_valid);

  // R2: self-test leaves the controller in its known state
  p_selftest_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_is_cmd && in_data == CMD_SELFTEST |=>
      ctrl_active && kbd_if_off && xlate_en && a20_en && cpu_reset_n &&
      out_valid && out_data == SELFTEST_OK);

  // R7: a keyboard byte re-enables the interface
  p_data_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_is_cmd && state == S_IDLE |=> kbd_valid && !kbd_if_off);

  // R7: a keyboard byte is held until taken
  p_kbd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && !kbd_ready |=> kbd_valid && $stable(kbd_data));

  // R9: no-op commands give no reply
  p_noop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_is_cmd && ctrl_active && dec.op == OP_NONE |=> !out_valid);
endmodule

// File: tb/kbc_host_cmd_tb.sv
module kbc_host_cmd_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_cmd = 1'b0, out_ready = 1'b0, kbd_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, kbd_valid, kbd_irq, kbd_if_off, xlate_en;
  logic a20_en, cpu_reset_n, ctrl_active, dump_req, poll_req;
  logic [7:0] out_data, kbd_data;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kbc_host_cmd u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_cmd(in_is_cmd), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .kbd_valid(kbd_valid),
    .kbd_ready(kbd_ready), .kbd_data(kbd_data), .kbd_irq(kbd_irq),
    .kbd_if_off(kbd_if_off), .xlate_en(xlate_en), .a20_en(a20_en),
    .cpu_reset_n(cpu_reset_n), .ctrl_active(ctrl_active),
    .dump_req(dump_req), .poll_req(poll_req)
  );

  // {req[3:0], is_cmd, byte[7:0], expect_reply, reply[7:0]}
  localparam int NV = 42;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'hAA, 1'b1, 8'h55},  // R2 self-test
    {4'd2, 1'b1, 8'h20, 1'b1, 8'h50},  // R2 command byte
    {4'd2, 1'b1, 8'h2B, 1'b1, 8'h20},  // R2 base
    {4'd8, 1'b1, 8'hD0, 1'b1, 8'h03},  // R8 output port
    {4'd3, 1'b1, 8'h61, 1'b0, 8'h00},  // R3 direct write
    {4'd3, 1'b0, 8'hA5, 1'b0, 8'h00},
    {4'd3, 1'b1, 8'h21, 1'b1, 8'hA5},  // R3 direct read
    {4'd4, 1'b1, 8'h01, 1'b1, 8'hA5},  // R4 alias
    {4'd4, 1'b1, 8'h6B, 1'b0, 8'h00},
    {4'd4, 1'b0, 8'h10, 1'b0, 8'h00},
    {4'd4, 1'b1, 8'h11, 1'b1, 8'hA5},  // R4 10h+11h
    {4'd4, 1'b1, 8'h6B, 1'b0, 8'h00},
    {4'd4, 1'b0, 8'h3C, 1'b0, 8'h00},
    {4'd4, 1'b1, 8'h45, 1'b0, 8'h00},  // R4 wrap to 01h
    {4'd4, 1'b0, 8'h77, 1'b0, 8'h00},
    {4'd4, 1'b1, 8'h05, 1'b1, 8'h77},
    {4'd4, 1'b1, 8'h2B, 1'b1, 8'h3C},
    {4'd4, 1'b1, 8'h6B, 1'b0, 8'h00},
    {4'd4, 1'b0, 8'h20, 1'b0, 8'h00},
    {4'd5, 1'b1, 8'h40, 1'b0, 8'h00},  // R5 relative write to 20h
    {4'd5, 1'b0, 8'hFF, 1'b0, 8'h00},
    {4'd5, 1'b1, 8'h20, 1'b1, 8'h77},
    {4'd5, 1'b1, 8'h60, 1'b0, 8'h00},
    {4'd5, 1'b0, 8'h50, 1'b0, 8'h00},
    {4'd5, 1'b1, 8'h20, 1'b1, 8'h50},
    {4'd8, 1'b1, 8'hD1, 1'b0, 8'h00},  // R8 write output port
    {4'd8, 1'b0, 8'h01, 1'b0, 8'h00},
    {4'd8, 1'b1, 8'hD0, 1'b1, 8'h01},
    {4'd8, 1'b1, 8'hD1, 1'b0, 8'h00},
    {4'd8, 1'b0, 8'h03, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'h80, 1'b0, 8'h00},  // R9 no-ops
    {4'd9, 1'b1, 8'hA8, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hAF, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hBF, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hC3, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hCF, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hD2, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hDE, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hE1, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'hEF, 1'b0, 8'h00},
    {4'd9, 1'b1, 8'h20, 1'b1, 8'h50},
    {4'd9, 1'b1, 8'hD0, 1'b1, 8'h03}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one byte; returns at the negedge after the accepting edge
  task automatic send(input bit c, input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_is_cmd = c; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic reply(input logic [7:0] b, input logic [7:0] exp, input string req);
    send(1'b1, b);
    chk(out_valid && out_data == exp, req, out_data, exp);
    if (out_valid) pop();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and ignored traffic before self-test
    chk(!ctrl_active && !out_valid && in_ready, "R1", ctrl_active, 0);
    chk(cpu_reset_n && kbd_if_off, "R1", {cpu_reset_n, kbd_if_off}, 3);
    send(1'b1, 8'h20);
    chk(!out_valid, "R1", out_valid, 0);
    send(1'b0, 8'h5A);
    chk(!kbd_valid && !ctrl_active, "R1", kbd_valid, 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [21:0] v = VEC[i];
      automatic string tag = $sformatf("R%0d vector %0d", v[21:18], i);
      send(v[17], v[16:9]);
      if (v[8]) begin
        chk(out_valid && out_data == v[7:0], tag, out_data, v[7:0]);
        if (out_valid) pop();
      end else begin
        chk(!out_valid, tag, out_valid, 0);
      end
    end
    chk(ctrl_active && xlate_en && a20_en && cpu_reset_n, "R2", ctrl_active, 1);

    // R6 interface enable / disable
    send(1'b1, 8'hAE);
    chk(!kbd_if_off, "R6", kbd_if_off, 0);
    send(1'b1, 8'hAD);
    chk(kbd_if_off, "R6", kbd_if_off, 1);

    // R7 keyboard byte under back-pressure, R11 in_ready low
    kbd_ready = 1'b0;
    send(1'b0, 8'h3C);
    chk(kbd_valid && kbd_data == 8'h3C, "R7", kbd_data, 8'h3C);
    chk(!kbd_if_off, "R7", kbd_if_off, 0);
    repeat (3) @(negedge clk);
    chk(kbd_valid && kbd_data == 8'h3C && !in_ready, "R11", kbd_valid, 1);
    kbd_ready = 1'b1;
    @(negedge clk);
    chk(!kbd_valid && in_ready, "R7", kbd_valid, 0);

    // R10 a new command cancels a parameter wait
    send(1'b1, 8'h61);
    send(1'b1, 8'hAD);
    send(1'b0, 8'h99);
    chk(kbd_valid && kbd_data == 8'h99 && !kbd_if_off, "R10", kbd_data, 8'h99);
    @(negedge clk);
    reply(8'h21, 8'hA5, "R10");

    // R12 interrupt with enable bit, R11 reply hold
    send(1'b1, 8'h60); send(1'b0, 8'h01);
    send(1'b1, 8'h20);
    chk(kbd_irq && out_data == 8'h01, "R12", kbd_irq, 1);
    repeat (2) @(negedge clk);
    chk(out_valid && out_data == 8'h01 && !in_ready, "R11", out_data, 8'h01);
    pop();
    chk(!kbd_irq && !out_valid, "R12", kbd_irq, 0);
    send(1'b1, 8'h60); send(1'b0, 8'h00);
    reply(8'h20, 8'h00, "R12");
    chk(!kbd_irq, "R12", kbd_irq, 0);

    // R13 request pulses
    send(1'b1, 8'hAC);
    chk(dump_req && !out_valid, "R13", dump_req, 1);
    @(negedge clk);
    chk(!dump_req, "R13", dump_req, 0);
    send(1'b1, 8'hC1);
    chk(poll_req && !out_valid, "R13", poll_req, 1);
    send(1'b1, 8'hC2);
    chk(poll_req, "R13", poll_req, 1);
    @(negedge clk);
    chk(!poll_req, "R13", poll_req, 0);

    // R8 reset line driven low, then R2 self-test restores the known state
    send(1'b1, 8'hD1); send(1'b0, 8'h00);
    chk(!cpu_reset_n && !a20_en, "R8", {a20_en, cpu_reset_n}, 0);
    send(1'b1, 8'h6B); send(1'b0, 8'h3C);
    reply(8'hAA, 8'h55, "R2");
    chk(cpu_reset_n && a20_en && kbd_if_off && xlate_en, "R2",
        {a20_en, cpu_reset_n, kbd_if_off, xlate_en}, 15);
    reply(8'h2B, 8'h20, "R2");
    reply(8'h20, 8'h50, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule